// File: doc/BRIEF.md
# Edge-Latched Bytewide Memory Core

This block models the device-side logic of a 32K x 8 bytewide memory that takes its address from the pins only once per access. The capture happens at the moment the active-low chip enable goes from high to low. After that, the address pins are ignored until chip enable has gone high (precharge) and low again. With chip enable low, a low write enable stores the byte on the data bus. Otherwise, a low output enable drives the stored byte at the captured address onto the bus. The bidirectional bus is split into an input byte, an output byte and an output-enable flag.

A fast internal clock samples the asynchronous pins. The storage is split into 32 banks of 1K x 8. The upper five address bits pick the bank. Within a bank, bits 9:8 pick the column and bits 7:0 pick the row. A small controller with three states sequences each access:

- **STANDBY**: chip enable high.
- **SELECT**: selected, no write in progress.
- **WRITE**: write enable held low.

The transitions are:

- **STANDBY to SELECT**: falling chip enable with write enable high.
- **STANDBY to WRITE**: falling chip enable with write enable already low.
- **SELECT to WRITE**: write enable falls.
- **WRITE to SELECT**: write enable rises while still selected. This is a commit.
- **WRITE to STANDBY**: chip enable rises. This is a commit.
- **SELECT to STANDBY**: chip enable rises.

Top module: `latched_byte_mem`

## Requirements
- R1: The core stores 32768 distinct bytes addressed by 15 bits. Bits 14:10 select one of 32 banks, bits 9:8 the column and bits 7:0 the row. Every address reads back the last byte written to it.
- R2: The address is captured at the first clock sample where `ce_n_i` is low after a sample where it was high.
- R3: While `ce_n_i` stays low, changes on `addr_i` change neither the byte read nor the location written.
- R4: While `ce_n_i` is high, `dq_oe_o` is 0 and no location is written, whatever `we_n_i` and `oe_n_i` are.
- R5: With `ce_n_i` low, `we_n_i` high and `oe_n_i` low, `dq_oe_o` is 1 and `dq_out_o` carries the byte at the captured address. This holds from the second clock edge after the falling-edge sample onward.
- R6: With `oe_n_i` high, `dq_oe_o` is 0.
- R7: With `ce_n_i` low and `we_n_i` low, a write takes place whatever `oe_n_i` is. It commits exactly once, at the first sample where `we_n_i` or `ce_n_i` is high, and stores the value of `dq_in_i` at that sample.
- R8: `dq_oe_o` is 0 while `we_n_i` is low, and in the cycle after a sample where it was low.
- R9: During and just after reset, the controller is in standby and `dq_oe_o` is 0. Array contents are undefined until written.
- R10: Several write pulses within one chip-enable low period each commit to the same captured address. A read in the same period returns the most recent byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 15 | Address pins |
| ce_n_i | input | 1 | Active-low chip enable |
| oe_n_i | input | 1 | Active-low output enable |
| we_n_i | input | 1 | Active-low write enable |
| dq_in_i | input | 8 | Data bus, inbound |
| dq_out_o | output | 8 | Data bus, outbound byte |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
The address capture and the start of a write can fall on the same sample: chip enable and write enable go low together. The commit on write-enable rise and the commit on chip-enable rise can also coincide. The bench provokes both by changing the two pins between the same pair of clock edges. It then judges the result by reading the location back in a fresh access and comparing against the byte driven at the commit sample. A stale or doubled capture would show up as a wrong byte at either the intended address or a neighbour.

// File: rtl/lbm_pkg.sv
`timescale 1ns/1ps
package lbm_pkg;
    localparam int ROW_W  = 8;
    localparam int COL_W  = 2;
    localparam int BLK_W  = 5;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_SELECT  = 2'd1,
        ST_WRITE   = 2'd2
    } lbm_state_e;
endpackage

// File: rtl/lbm_addr_latch.sv
`timescale 1ns/1ps
module lbm_addr_latch #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ce_fall_o,
    output logic [ADDR_W-1:0] addr_lat_o
);
    logic ce_prev_q;

    assign ce_fall_o = ce_prev_q & ~ce_n_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_prev_q  <= 1'b1;
            addr_lat_o <= '0;
        end else begin
            ce_prev_q <= ce_n_i;
            if (ce_fall_o) begin
                addr_lat_o <= addr_i;
            end
        end
    end

    AST_LATCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_prev_q && !ce_n_i) |=> (addr_lat_o == $past(addr_i))); // R2

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_prev_q && !ce_n_i) |=> $stable(addr_lat_o)); // R3
endmodule

// File: rtl/lbm_ctrl_fsm.sv
`timescale 1ns/1ps
module lbm_ctrl_fsm
    import lbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_i,
    input  logic we_n_i,
    input  logic ce_fall_i,
    output logic wr_commit_o,
    output logic rd_valid_o
);
    lbm_state_e state_q, state_d;
    logic       rd_valid_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_STANDBY;
            rd_valid_o <= 1'b0;
        end else begin
            state_q    <= state_d;
            rd_valid_o <= rd_valid_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY: begin
                if (ce_fall_i) begin
                    state_d = we_n_i ? ST_SELECT : ST_WRITE;
                end
            end
            ST_SELECT: begin
                if (ce_n_i) begin
                    state_d = ST_STANDBY;
                end else if (!we_n_i) begin
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (ce_n_i) begin
                    state_d = ST_STANDBY;
                end else if (we_n_i) begin
                    state_d = ST_SELECT;
                end
            end
            default: state_d = ST_STANDBY;
        endcase
    end

    always_comb begin
        wr_commit_o = 1'b0;
        rd_valid_d  = 1'b0;
        unique case (state_q)
            ST_STANDBY: begin
                rd_valid_d = 1'b0;
            end
            ST_SELECT: begin
                rd_valid_d = (state_d == ST_SELECT);
            end
            ST_WRITE: begin
                wr_commit_o = ce_n_i | we_n_i;
            end
            default: begin
                wr_commit_o = 1'b0;
            end
        endcase
    end

    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |=> !wr_commit_o); // R7

    AST_COMMIT_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> $past(!ce_n_i)); // R4
endmodule

// File: rtl/lbm_array.sv
`timescale 1ns/1ps
module lbm_array #(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 2,
    parameter int BLK_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int NUM_BLK    = 1 << BLK_W;
    localparam int IDX_W      = ROW_W + COL_W;
    localparam int BANK_DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] bank_rd [NUM_BLK];

    assign idx = {col_i, row_i};

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_bank
        logic [DATA_W-1:0] cells [BANK_DEPTH];
        logic              hit;

        assign hit = (blk_i == BLK_W'(g));

        always_ff @(posedge clk) begin
            if (wr_en_i && hit) begin
                cells[idx] <= wdata_i;
            end
        end

        assign bank_rd[g] = cells[idx];
    end

    assign rdata_o = bank_rd[blk_i];
endmodule

// File: rtl/latched_byte_mem.sv
`timescale 1ns/1ps
module latched_byte_mem
    import lbm_pkg::*;
#(
    parameter int ROW_BITS  = ROW_W,
    parameter int COL_BITS  = COL_W,
    parameter int BLK_BITS  = BLK_W,
    parameter int DATA_BITS = DATA_W,
    localparam int AW       = ROW_BITS + COL_BITS + BLK_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr_i,
    input  logic                 ce_n_i,
    input  logic                 oe_n_i,
    input  logic                 we_n_i,
    input  logic [DATA_BITS-1:0] dq_in_i,
    output logic [DATA_BITS-1:0] dq_out_o,
    output logic                 dq_oe_o
);
    logic                 ce_fall;
    logic [AW-1:0]        addr_lat;
    logic                 wr_commit;
    logic                 rd_valid;
    logic [DATA_BITS-1:0] arr_rd;
    logic [DATA_BITS-1:0] io_latch_q;

    lbm_addr_latch #(.ADDR_W(AW)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n_i     (ce_n_i),
        .addr_i     (addr_i),
        .ce_fall_o  (ce_fall),
        .addr_lat_o (addr_lat)
    );

    lbm_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_n_i      (ce_n_i),
        .we_n_i      (we_n_i),
        .ce_fall_i   (ce_fall),
        .wr_commit_o (wr_commit),
        .rd_valid_o  (rd_valid)
    );

    lbm_array #(
        .ROW_W  (ROW_BITS),
        .COL_W  (COL_BITS),
        .BLK_W  (BLK_BITS),
        .DATA_W (DATA_BITS)
    ) u_array (
        .clk     (clk),
        .wr_en_i (wr_commit),
        .blk_i   (addr_lat[AW-1 -: BLK_BITS]),
        .col_i   (addr_lat[ROW_BITS +: COL_BITS]),
        .row_i   (addr_lat[ROW_BITS-1:0]),
        .wdata_i (dq_in_i),
        .rdata_o (arr_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_latch_q <= '0;
        end else begin
            io_latch_q <= arr_rd;
        end
    end

    assign dq_out_o = io_latch_q;
    assign dq_oe_o  = rd_valid & ~oe_n_i & we_n_i & ~ce_n_i;

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> $past(we_n_i)); // R8

    AST_DRIVE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> $past(!ce_n_i)); // R5
endmodule

// File: tb/sim_latched_byte_mem.sv
`timescale 1ns/1ps
module sim_latched_byte_mem;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] addr;
    logic        ce_n, oe_n, we_n;
    logic [7:0]  dq_in;
    logic [7:0]  dq_out;
    logic        dq_oe;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    latched_byte_mem u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr),
        .ce_n_i   (ce_n),
        .oe_n_i   (oe_n),
        .we_n_i   (we_n),
        .dq_in_i  (dq_in),
        .dq_out_o (dq_out),
        .dq_oe_o  (dq_oe)
    );

    // {address, data}
    localparam logic [22:0] VEC [8] = '{
        {15'h0000, 8'hA5}, {15'h7FFF, 8'h5A}, {15'h03FF, 8'h11}, {15'h0400, 8'h22},
        {15'h0100, 8'h33}, {15'h0200, 8'h44}, {15'h0001, 8'h55}, {15'h7C00, 8'h66}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_cycle(input logic [14:0] a, input logic [7:0] d, input logic oe);
        ce_n = 1'b1; we_n = 1'b1; tick(2);
        addr = a; dq_in = d; oe_n = oe; we_n = 1'b0; ce_n = 1'b0; tick(1);
        chk("R8 no drive during write", {7'd0, dq_oe}, 8'd0);
        tick(1);
        we_n = 1'b1; tick(1);
        ce_n = 1'b1; oe_n = 1'b1; tick(2);
    endtask

    task automatic read_cycle(input logic [14:0] a, input logic [7:0] exp, input string tag);
        ce_n = 1'b1; we_n = 1'b1; tick(2);
        addr = a; oe_n = 1'b0; ce_n = 1'b0; tick(3);
        chk({tag, " oe"}, {7'd0, dq_oe}, 8'd1);
        chk({tag, " data"}, dq_out, exp);
        ce_n = 1'b1; oe_n = 1'b1; tick(2);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; addr = '0; ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; dq_in = '0;
        tick(3);
        chk("R9 reset no drive", {7'd0, dq_oe}, 8'd0);
        rst_n = 1'b1; tick(2);
        chk("R9 idle no drive", {7'd0, dq_oe}, 8'd0);
        oe_n = 1'b1;

        // R1 R7: table of writes (oe high), then read back every location (R5)
        for (int i = 0; i < 8; i++) write_cycle(VEC[i][22:8], VEC[i][7:0], 1'b1);
        for (int i = 0; i < 8; i++) read_cycle(VEC[i][22:8], VEC[i][7:0], "R1 R5 table");

        // R3: address moves during a read selection
        ce_n = 1'b1; tick(2);
        addr = 15'h0000; oe_n = 1'b0; ce_n = 1'b0; tick(1);
        addr = 15'h7FFF; tick(3);
        chk("R3 read ignores addr change", dq_out, 8'hA5);
        // R6: output enable high releases bus, low drives again
        oe_n = 1'b1; tick(1);
        chk("R6 oe high tristate", {7'd0, dq_oe}, 8'd0);
        oe_n = 1'b0; tick(1);
        chk("R6 oe low drives", {7'd0, dq_oe}, 8'd1);
        // R2: new capture only after precharge
        ce_n = 1'b1; oe_n = 1'b1; tick(2);
        read_cycle(15'h7FFF, 8'h5A, "R2 recapture");

        // R3: address moves during a write selection
        ce_n = 1'b1; tick(2);
        addr = 15'h0001; ce_n = 1'b0; tick(1);
        addr = 15'h0100; dq_in = 8'h77; we_n = 1'b0; tick(2);
        we_n = 1'b1; tick(1);
        ce_n = 1'b1; tick(2);
        read_cycle(15'h0001, 8'h77, "R3 write to captured");
        read_cycle(15'h0100, 8'h33, "R3 other untouched");

        // R4: standby ignores write and output enable
        ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b0; addr = 15'h0000; dq_in = 8'hFF; tick(4);
        chk("R4 standby no drive", {7'd0, dq_oe}, 8'd0);
        we_n = 1'b1; oe_n = 1'b1; tick(2);
        read_cycle(15'h0000, 8'hA5, "R4 standby no write");

        // R7: write with output enable low
        write_cycle(15'h0200, 8'hC3, 1'b0);
        read_cycle(15'h0200, 8'hC3, "R7 write with oe low");

        // R7: commit on chip-enable rise, data taken at commit sample
        ce_n = 1'b1; tick(2);
        addr = 15'h0400; dq_in = 8'h12; we_n = 1'b0; ce_n = 1'b0; tick(2);
        dq_in = 8'h9E; tick(1);
        ce_n = 1'b1; tick(1);
        dq_in = 8'h00; we_n = 1'b1; tick(2);
        read_cycle(15'h0400, 8'h9E, "R7 commit on ce rise");

        // R7: ce and we rise on the same sample
        ce_n = 1'b1; tick(2);
        addr = 15'h03FF; dq_in = 8'hE1; we_n = 1'b0; ce_n = 1'b0; tick(2);
        we_n = 1'b1; ce_n = 1'b1; tick(2);
        read_cycle(15'h03FF, 8'hE1, "R7 joint rise");

        // R10: two write pulses in one selection, read in between
        ce_n = 1'b1; tick(2);
        addr = 15'h0001; oe_n = 1'b0; ce_n = 1'b0; tick(1);
        dq_in = 8'h10; we_n = 1'b0; tick(2);
        we_n = 1'b1; tick(3);
        chk("R10 first pulse read", dq_out, 8'h10);
        dq_in = 8'h20; we_n = 1'b0; tick(1);
        chk("R8 no drive we low", {7'd0, dq_oe}, 8'd0);
        tick(1);
        we_n = 1'b1; tick(3);
        chk("R10 second pulse read", dq_out, 8'h20);
        ce_n = 1'b1; oe_n = 1'b1; tick(2);
        read_cycle(15'h0001, 8'h20, "R10 final");

        finish_up();
    end
endmodule